// File: doc/BRIEF.md
# Oversampling asynchronous serial receiver

This block recovers characters from a single asynchronous serial line that shares no clock with the system. A programmable divisor turns the system clock into a tick at sixteen times the bit rate. The line passes through a two-flop synchroniser. A falling edge on an armed line starts a frame. The start bit is re-checked half a bit later, and the first data bit is sampled one and a half bit times after the edge. Every later bit is sampled one bit time after the one before.

The frame holds 7, 8 or 9 data bits, least significant first. An optional even or odd parity bit follows, then one or two stop bits. The received word is presented with a one-cycle data-ready strobe. Parity and framing errors are reported alongside that strobe. An idle flag rises once the line has stayed high for longer than one full character. A consumer acknowledges each word. A word that completes while the previous one is still unacknowledged is dropped and raises a sticky overrun flag.

Top module: `serial_rx_core`

## Requirements
- R1: One bit time equals 32 times `divisor` system clocks, which is 16 oversample ticks of 2 times `divisor` clocks each. A character sent at that rate is decoded correctly for any nonzero divisor.
- R2: `word_sel` selects the data width: 0 gives 7 bits, 1 gives 8 bits, 2 or 3 gives 9 bits. The first data bit received lands in `rx_data[0]`. Bits above the selected width read as zero.
- R3: A low pulse shorter than half a bit time that is still high at the start-bit midpoint (tick 8) is discarded, and no data-ready strobe follows it.
- R4: When `par_en` is 1, a parity bit follows the data. `par_odd`=0 requires an even total of ones across data and parity, and `par_odd`=1 requires an odd total. A mismatch raises `parity_err` together with `rx_valid`.
- R5: `two_stop` selects one or two stop bits. A low sample at any stop-bit position raises `frame_err` together with `rx_valid`.
- R6: Each completed character that is accepted gives exactly one single-cycle `rx_valid` pulse. `parity_err` and `frame_err` are never high without `rx_valid`.
- R7: `line_idle` rises only after the synchronised line has been high for more than one character time: 16 ticks times (1 + data bits + parity bit + stop bits). It drops as soon as the line is seen low.
- R8: A character completing while the previous word is unacknowledged leaves `rx_data` unchanged, gives no `rx_valid`, and sets `overrun`. `rd_ack` clears both the held state and `overrun`. An `rd_ack` in the same cycle as a completion accepts the new word without overrun.
- R9: A start is accepted only on a falling edge after the line has been seen high. A line held low from reset produces no character.
- R10: After reset, `rx_valid`, `parity_err`, `frame_err`, `overrun`, `line_idle` and `rx_data` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| divisor | input | DIV_W | Baud divisor; bit time is 32 x divisor clocks |
| word_sel | input | 2 | Data width select (0: 7, 1: 8, 2/3: 9 bits) |
| par_en | input | 1 | Parity bit present |
| par_odd | input | 1 | 1 selects odd parity, 0 selects even |
| two_stop | input | 1 | 1 selects two stop bits |
| rx_line | input | 1 | Asynchronous serial input, high at rest |
| rd_ack | input | 1 | Consumer acknowledges the presented word |
| rx_data | output | DATA_W | Last accepted word, LSB first on the line |
| rx_valid | output | 1 | One-cycle strobe for a newly accepted word |
| parity_err | output | 1 | Parity mismatch, valid with rx_valid |
| frame_err | output | 1 | Low stop bit, valid with rx_valid |
| overrun | output | 1 | Sticky: a word was lost before acknowledge |
| line_idle | output | 1 | Line high for longer than one character |

## Verification
A frame completing and a read acknowledge can land in the same clock. The block must then accept the new word rather than report an overrun. The bench provokes this by leaving one word unacknowledged and sending a second one. It sweeps a single-cycle acknowledge across every clock around the centre of the second word's stop bit. In each trial it judges the outcome: either the new word arrived with no overrun seen, or the older word was kept and the overrun flag was raised. At least one trial must show the strobe exactly one cycle after the acknowledge, which proves that the exact coincidence was hit and resolved in favour of the new word.

// File: rtl/srx_pkg.sv
package srx_pkg;
  typedef enum logic [2:0] {
    S_HUNT,
    S_START,
    S_DATA,
    S_PAR,
    S_STOP
  } srx_state_e;

  localparam int OVS_RATE  = 16;  // ticks per bit
  localparam int START_MID = 8;   // start-bit recheck tick
  localparam int FIRST_MID = 24;  // first data-bit sample tick

  function automatic logic [3:0] word_len(input logic [1:0] sel);
    case (sel)
      2'd0:    word_len = 4'd7;
      2'd1:    word_len = 4'd8;
      default: word_len = 4'd9;
    endcase
  endfunction
endpackage

// File: rtl/srx_tick_gen.sv
module srx_tick_gen #(
  parameter int DIV_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] divisor,
  output logic             tick
);
  localparam int CW = DIV_W + 1;

  logic [CW-1:0] cnt, cnt_n, lim;
  logic          tick_n;

  assign lim = {divisor, 1'b0} - CW'(1);

  always_comb begin
    if (cnt >= lim) begin
      cnt_n  = '0;
      tick_n = 1'b1;
    end else begin
      cnt_n  = cnt + CW'(1);
      tick_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else begin
      cnt  <= cnt_n;
      tick <= tick_n;
    end
  end
endmodule

// File: rtl/srx_line_sync.sv
module srx_line_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic line_in,
  output logic line_s
);
  logic meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta   <= 1'b0;
      line_s <= 1'b0;
    end else begin
      meta   <= line_in;
      line_s <= meta;
    end
  end
endmodule

// File: rtl/srx_frame.sv
module srx_frame
  import srx_pkg::*;
#(
  parameter int DATA_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              rxs,
  input  logic [3:0]        nbits,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              two_stop,
  output logic              done,
  output logic [DATA_W-1:0] word,
  output logic              perr,
  output logic              ferr
);
  localparam int CNT_W = $clog2(FIRST_MID);
  localparam int IDX_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] C_MID   = CNT_W'(START_MID - 1);
  localparam logic [CNT_W-1:0] C_FIRST = CNT_W'(FIRST_MID - 1);
  localparam logic [CNT_W-1:0] C_BIT   = CNT_W'(OVS_RATE - 1);

  srx_state_e        st, st_n;
  logic [CNT_W-1:0]  tcnt, tcnt_n;
  logic [IDX_W-1:0]  bidx, bidx_n;
  logic [DATA_W-1:0] word_n;
  logic              pacc, pacc_n, perr_n, ferr_n;
  logic              stop2, stop2_n, armed, armed_n, done_n;

  always_comb begin
    st_n    = st;
    tcnt_n  = tcnt;
    bidx_n  = bidx;
    word_n  = word;
    pacc_n  = pacc;
    perr_n  = perr;
    ferr_n  = ferr;
    stop2_n = stop2;
    armed_n = armed;
    done_n  = 1'b0;
    unique case (st)
      S_HUNT: begin
        if (rxs) armed_n = 1'b1;
        else if (armed) begin
          st_n    = S_START;
          tcnt_n  = '0;
          word_n  = '0;
          pacc_n  = 1'b0;
          perr_n  = 1'b0;
          ferr_n  = 1'b0;
          stop2_n = 1'b0;
          armed_n = 1'b0;
        end
      end
      S_START: if (tick) begin
        if (tcnt == C_FIRST) begin
          word_n[0] = rxs;
          pacc_n    = rxs;
          bidx_n    = IDX_W'(1);
          tcnt_n    = '0;
          st_n      = S_DATA;
        end else begin
          tcnt_n = tcnt + CNT_W'(1);
          if (tcnt == C_MID && rxs) st_n = S_HUNT;  // glitch, not a start
        end
      end
      S_DATA: if (tick) begin
        if (tcnt == C_BIT) begin
          word_n[bidx] = rxs;
          pacc_n       = pacc ^ rxs;
          tcnt_n       = '0;
          bidx_n       = bidx + IDX_W'(1);
          if (bidx == IDX_W'(nbits - 4'd1)) st_n = par_en ? S_PAR : S_STOP;
        end else tcnt_n = tcnt + CNT_W'(1);
      end
      S_PAR: if (tick) begin
        if (tcnt == C_BIT) begin
          perr_n = pacc ^ rxs ^ par_odd;
          tcnt_n = '0;
          st_n   = S_STOP;
        end else tcnt_n = tcnt + CNT_W'(1);
      end
      S_STOP: if (tick) begin
        if (tcnt == C_BIT) begin
          ferr_n = ferr | ~rxs;
          tcnt_n = '0;
          if (two_stop && !stop2) stop2_n = 1'b1;
          else begin
            done_n = 1'b1;
            st_n   = S_HUNT;
          end
        end else tcnt_n = tcnt + CNT_W'(1);
      end
      default: st_n = S_HUNT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_HUNT;
      tcnt  <= '0;
      bidx  <= '0;
      word  <= '0;
      pacc  <= 1'b0;
      perr  <= 1'b0;
      ferr  <= 1'b0;
      stop2 <= 1'b0;
      armed <= 1'b0;
      done  <= 1'b0;
    end else begin
      st    <= st_n;
      tcnt  <= tcnt_n;
      bidx  <= bidx_n;
      word  <= word_n;
      pacc  <= pacc_n;
      perr  <= perr_n;
      ferr  <= ferr_n;
      stop2 <= stop2_n;
      armed <= armed_n;
      done  <= done_n;
    end
  end
endmodule

// File: rtl/serial_rx_core.sv
module serial_rx_core
  import srx_pkg::*;
#(
  parameter int DIV_W  = 12,
  parameter int DATA_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  divisor,
  input  logic [1:0]        word_sel,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              two_stop,
  input  logic              rx_line,
  input  logic              rd_ack,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              parity_err,
  output logic              frame_err,
  output logic              overrun,
  output logic              line_idle
);
  localparam int IDLE_W = $clog2(OVS_RATE * (DATA_W + 4) + 1);

  logic [1:0]        rst_q;
  logic              rst_i_n;
  logic              tick, rxs, done, perr, ferr;
  logic [DATA_W-1:0] word;
  logic [3:0]        nbits, frame_bits;
  logic [IDLE_W-1:0] idle_cnt, idle_cnt_n, char_ticks;
  logic [DATA_W-1:0] data_n;
  logic              valid_n, pe_n, fe_n, full, full_n, ovr_n;

  // reset: asserted at once, released after two clocks
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_i_n = rst_q[1];

  assign nbits = word_len(word_sel);

  srx_tick_gen #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst_n(rst_i_n), .divisor(divisor), .tick(tick)
  );

  srx_line_sync u_sync (
    .clk(clk), .rst_n(rst_i_n), .line_in(rx_line), .line_s(rxs)
  );

  srx_frame #(.DATA_W(DATA_W)) u_frame (
    .clk(clk), .rst_n(rst_i_n), .tick(tick), .rxs(rxs), .nbits(nbits),
    .par_en(par_en), .par_odd(par_odd), .two_stop(two_stop),
    .done(done), .word(word), .perr(perr), .ferr(ferr)
  );

  // idle detection: ticks of continuous high line against one character
  assign frame_bits = 4'd2 + nbits + {3'b000, par_en} + {3'b000, two_stop};
  assign char_ticks = IDLE_W'(frame_bits) * IDLE_W'(OVS_RATE);
  assign line_idle  = idle_cnt > char_ticks;

  always_comb begin
    if (!rxs)                          idle_cnt_n = '0;
    else if (tick && idle_cnt != '1)   idle_cnt_n = idle_cnt + IDLE_W'(1);
    else                               idle_cnt_n = idle_cnt;
  end

  // output holding stage with overrun protection
  always_comb begin
    data_n  = rx_data;
    valid_n = 1'b0;
    pe_n    = 1'b0;
    fe_n    = 1'b0;
    full_n  = full;
    ovr_n   = overrun;
    if (rd_ack) begin
      full_n = 1'b0;
      ovr_n  = 1'b0;
    end
    if (done) begin
      if (full && !rd_ack) ovr_n = 1'b1;
      else begin
        data_n  = word;
        valid_n = 1'b1;
        pe_n    = perr;
        fe_n    = ferr;
        full_n  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      idle_cnt   <= '0;
      rx_data    <= '0;
      rx_valid   <= 1'b0;
      parity_err <= 1'b0;
      frame_err  <= 1'b0;
      full       <= 1'b0;
      overrun    <= 1'b0;
    end else begin
      idle_cnt   <= idle_cnt_n;
      rx_data    <= data_n;
      rx_valid   <= valid_n;
      parity_err <= pe_n;
      frame_err  <= fe_n;
      full       <= full_n;
      overrun    <= ovr_n;
    end
  end
endmodule

// File: rtl/serial_rx_chk.sv
module serial_rx_chk #(
  parameter int DIV_W  = 12,
  parameter int DATA_W = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic [DIV_W-1:0]  divisor,
  input logic              tick,
  input logic              rxs,
  input logic              rx_valid,
  input logic              parity_err,
  input logic              frame_err,
  input logic              overrun,
  input logic [DATA_W-1:0] rx_data,
  input logic              line_idle
);
  // R1: with a nonzero divisor the oversample tick never lasts two cycles
  a_r1_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
    (divisor != '0 && tick) |=> !tick);

  // R6: data-ready is a single-cycle strobe
  a_r6_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  // R6: error flags only accompany the strobe
  a_r6_flags_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (parity_err || frame_err) |-> rx_valid);

  // R8: raising overrun leaves the held word untouched and gives no strobe
  a_r8_overrun_keeps_word: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> ($stable(rx_data) && !rx_valid));

  // R7: a low synchronised line clears the idle indication next cycle
  a_r7_idle_drops: assert property (@(posedge clk) disable iff (!rst_n)
    !rxs |=> !line_idle);
endmodule

bind serial_rx_core serial_rx_chk #(.DIV_W(DIV_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .divisor(divisor), .tick(tick), .rxs(rxs),
  .rx_valid(rx_valid), .parity_err(parity_err), .frame_err(frame_err),
  .overrun(overrun), .rx_data(rx_data), .line_idle(line_idle)
);

// File: tb/sim_serial_rx_core.sv
module sim_serial_rx_core;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [11:0] divisor;
  logic [1:0]  word_sel;
  logic        par_en, par_odd, two_stop, rx_line, rd_ack;
  logic [8:0]  rx_data;
  logic        rx_valid, parity_err, frame_err, overrun, line_idle;

  int checks = 0, failures = 0;
  int cyc = 0, vcnt = 0, ovr_cnt = 0, vld_cyc = 0, ack_cyc = -10;
  int bit_len = 64;
  logic [8:0] cap_data;
  logic       cap_pe, cap_fe;

  always #2.5 clk = ~clk;  // 200 MHz
  always @(posedge clk) cyc <= cyc + 1;

  serial_rx_core u0 (
    .clk(clk), .rst_n(rst_n), .divisor(divisor), .word_sel(word_sel),
    .par_en(par_en), .par_odd(par_odd), .two_stop(two_stop),
    .rx_line(rx_line), .rd_ack(rd_ack), .rx_data(rx_data),
    .rx_valid(rx_valid), .parity_err(parity_err), .frame_err(frame_err),
    .overrun(overrun), .line_idle(line_idle)
  );

  always @(negedge clk) begin
    if (rx_valid) begin
      vcnt     = vcnt + 1;
      vld_cyc  = cyc;
      cap_data = rx_data;
      cap_pe   = parity_err;
      cap_fe   = frame_err;
    end
    if (overrun) ovr_cnt = ovr_cnt + 1;
  end

  // {sel[15:14], parity_en[13], odd[12], two_stop[11], bad_par[10], bad_stop[9], data[8:0]}
  function automatic logic [15:0] mkv(input logic [1:0] s, input logic pe, po, tw,
                                      bp, bs, input logic [8:0] d);
    mkv = {s, pe, po, tw, bp, bs, d};
  endfunction

  localparam int NV = 11;
  localparam logic [15:0] VEC [NV] = '{
    mkv(2'd1, 0, 0, 0, 0, 0, 9'h0A5),  // 8N1
    mkv(2'd0, 0, 0, 0, 0, 0, 9'h1FF),  // 7N1, upper bits must read zero
    mkv(2'd2, 0, 0, 0, 0, 0, 9'h1A3),  // 9N1
    mkv(2'd1, 1, 0, 0, 0, 0, 9'h03C),  // 8E1 good
    mkv(2'd1, 1, 1, 0, 0, 0, 9'h03C),  // 8O1 good
    mkv(2'd1, 1, 0, 0, 1, 0, 9'h081),  // 8E1 bad parity
    mkv(2'd1, 1, 1, 1, 0, 0, 9'h05A),  // 8O2 good
    mkv(2'd1, 0, 0, 0, 0, 1, 9'h000),  // 8N1 low stop
    mkv(2'd1, 0, 0, 1, 0, 1, 9'h0FF),  // 8N2 second stop low
    mkv(2'd3, 1, 1, 0, 1, 0, 9'h155),  // 9O1 bad parity
    mkv(2'd0, 1, 0, 1, 0, 0, 9'h055)   // 7E2 good
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive_bit(input logic v, input int ack_at);
    for (int i = 0; i < bit_len; i++) begin
      @(negedge clk);
      rx_line = v;
      rd_ack  = (i == ack_at);
      if (i == ack_at) ack_cyc = cyc;
    end
  endtask

  function automatic int nb_of(input logic [1:0] s);
    return (s == 2'd0) ? 7 : (s == 2'd1) ? 8 : 9;
  endfunction

  task automatic send(input logic [1:0] s, input logic pe, po, tw, bp, bs,
                      input logic [8:0] d, input int ack_at);
    int nb;
    logic [8:0] m;
    nb = nb_of(s);
    m  = 9'h1FF >> (9 - nb);
    @(negedge clk);
    word_sel = s; par_en = pe; par_odd = po; two_stop = tw;
    drive_bit(1'b0, -1);
    for (int i = 0; i < nb; i++) drive_bit(d[i], -1);
    if (pe) drive_bit((^(d & m)) ^ po ^ bp, -1);
    if (tw) drive_bit(1'b1, -1);
    drive_bit(!bs, ack_at);
    rx_line = 1'b1;
    rd_ack  = 1'b0;
    repeat (3 * bit_len) @(negedge clk);
  endtask

  task automatic ack();
    @(negedge clk) rd_ack = 1'b1;
    @(negedge clk) rd_ack = 1'b0;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    failures++;
    $display("FAIL R6 watchdog actual=hung expected=complete");
    finish_run();
  end

  initial begin
    int v0, o0, hits;
    logic [15:0] v;
    logic [8:0] m;
    rst_n = 1'b0; rx_line = 1'b1; rd_ack = 1'b0; divisor = 12'd2;
    word_sel = 2'd1; par_en = 0; par_odd = 0; two_stop = 0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R10 reset state
    chk("R10 rx_valid", rx_valid, 0);
    chk("R10 parity_err", parity_err, 0);
    chk("R10 frame_err", frame_err, 0);
    chk("R10 overrun", overrun, 0);
    chk("R10 line_idle", line_idle, 0);
    chk("R10 rx_data", rx_data, 0);

    // R7 idle threshold: 8N1 character = 160 ticks = 640 clocks
    repeat (560) @(negedge clk);
    chk("R7 not idle before one character", line_idle, 0);
    repeat (220) @(negedge clk);
    chk("R7 idle after one character", line_idle, 1);

    // vector table: R2 width/order, R4 parity, R5 stop bits, R6 single strobe
    for (int k = 0; k < NV; k++) begin
      v  = VEC[k];
      m  = 9'h1FF >> (9 - nb_of(v[15:14]));
      v0 = vcnt;
      send(v[15:14], v[13], v[12], v[11], v[10], v[9], v[8:0], -1);
      chk("R6 one strobe per character", vcnt - v0, 1);
      chk("R2 received word", cap_data, v[8:0] & m);
      chk("R4 parity flag", cap_pe, v[13] & v[10]);
      chk("R5 framing flag", cap_fe, v[9]);
      ack();
    end

    // R1 other divisor
    divisor = 12'd3; bit_len = 96;
    v0 = vcnt;
    send(2'd1, 0, 0, 0, 0, 0, 9'h096, -1);
    chk("R1 strobe at divisor 3", vcnt - v0, 1);
    chk("R1 word at divisor 3", cap_data, 9'h096);
    ack();
    divisor = 12'd2; bit_len = 64;

    // R3 glitch rejection, R7 idle drop
    repeat (12 * 64) @(negedge clk);
    chk("R7 idle before glitch", line_idle, 1);
    rx_line = 1'b0;
    repeat (5) @(negedge clk);
    chk("R7 idle drops on low line", line_idle, 0);
    repeat (15) @(negedge clk);
    rx_line = 1'b1;
    v0 = vcnt;
    repeat (22 * 64) @(negedge clk);
    chk("R3 glitch gives no strobe", vcnt - v0, 0);

    // R8 overrun keeps older word
    v0 = vcnt;
    send(2'd1, 0, 0, 0, 0, 0, 9'h011, -1);
    send(2'd1, 0, 0, 0, 0, 0, 9'h022, -1);
    chk("R8 overrun set", overrun, 1);
    chk("R8 older word kept", rx_data, 9'h011);
    chk("R8 only one strobe", vcnt - v0, 1);
    ack();
    @(negedge clk);
    chk("R8 overrun cleared by ack", overrun, 0);

    // R8 acknowledge swept across the completion cycle
    hits = 0;
    for (int off = 26; off <= 44; off++) begin
      send(2'd1, 0, 0, 0, 0, 0, 9'h00F, -1);
      v0 = vcnt; o0 = ovr_cnt;
      send(2'd1, 0, 0, 0, 0, 0, 9'h0F0, off);
      if (vcnt != v0) begin
        chk("R8 new word accepted", cap_data, 9'h0F0);
        chk("R8 no overrun when acked in time", ovr_cnt - o0, 0);
        if (vld_cyc == ack_cyc + 1) hits++;
      end else begin
        chk("R8 older word on late ack", rx_data, 9'h00F);
        chk("R8 overrun on late ack", (ovr_cnt > o0) ? 1 : 0, 1);
      end
      ack();
    end
    chk("R8 ack coincident with completion seen", (hits > 0) ? 1 : 0, 1);

    // R9 line low out of reset: no start
    @(negedge clk);
    rst_n = 1'b0; rx_line = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    v0 = vcnt;
    repeat (26 * 64) @(negedge clk);
    chk("R9 no character from stuck-low line", vcnt - v0, 0);
    chk("R9 not idle while low", line_idle, 0);
    rx_line = 1'b1;
    repeat (3 * 64) @(negedge clk);
    send(2'd1, 0, 0, 0, 0, 0, 9'h03C, -1);
    chk("R9 recovers after line rises", vcnt - v0, 1);
    chk("R9 word after recovery", cap_data, 9'h03C);

    finish_run();
  end
endmodule